// File: doc/BRIEF.md
# Two-Way Set-Associative First-Level Cache

This block is a 1 KB first-level cache with two ways and 64 sets. Each line is 8 bytes and holds two 32-bit longwords. The set is picked by address bits 8:3, and longword bit 2 selects the word within the line. Translation never changes these bits, so the set can be read while the physical tag is still being translated. The translated tag is then compared inside the same cycle, and a hit returns its data combinationally.

A bus controller fills lines. It first allocates a line in a set, which picks a victim way and writes the new tag. It then writes the two longwords in either order, each with the parity bits that came over the bus. A line becomes valid only when both longwords have arrived and no error was flagged.

Each stored byte has its own parity bit. A parity mismatch on the addressed longword turns a hit into a miss. An external agent can invalidate a line by giving its set and tag. A mode input restricts caching to instruction fetches. A row pointer, built from a full-period shift register, steps through every set on idle cycles so that the rows can be refreshed.

Top module: `l1c_top`

## Requirements
- R1: A read looks up set `rd_vaddr_i[8:3]` and longword `rd_vaddr_i[2]`, and compares the stored tag against `rd_ptag_i`. `rd_hit_o` and `rd_data_o` are combinational in the cycle of the request. A tag mismatch is a miss.
- R2: After reset, every line is invalid, so every read misses.
- R3: A fill is an allocate pulse followed by two longword writes, given by `fill_we_i` and `fill_lw_i`. The line misses until the clock edge that stores its second longword, and it hits from then on.
- R4: If `fill_err_i` is high on either longword write, the line never becomes valid.
- R5: On allocation, the victim is the invalid way if there is one, with way 0 checked before way 1. When both ways are valid, a pseudo-random bit picks the victim, and exactly one of the two resident lines is displaced.
- R6: Parity is even per byte: `par[k]` is the XOR of data bits 8k+7..8k. On a read, a mismatch in any byte of the addressed longword forces a miss. The other longword of the same line still hits.
- R7: When `icache_only_i` is 1, reads with `rd_instr_i` = 0 miss and instruction reads hit. When it is 0, both kinds hit. Switching the mode loses no content.
- R8: An invalidate clears only the way whose tag matches `inv_tag_i` in set `inv_idx_i`. A non-matching tag, or the other way, is left intact.
- R9: An invalidate to the set of a fill in progress, including the cycle of its last write, aborts that fill, and the line stays invalid. An invalidate to another set does not abort it.
- R10: `rfsh_row_o` is 0 in reset. It advances on every idle cycle (no read, allocate, write or invalidate) and holds on busy cycles. Over 64 consecutive idle cycles it visits all 64 rows.
- R11: `rd_hit_o` is never high without `rd_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| icache_only_i | input | 1 | 1 caches instruction fetches only |
| rd_req_i | input | 1 | Read lookup request |
| rd_instr_i | input | 1 | Request is an instruction fetch |
| rd_vaddr_i | input | 7 | Untranslated address bits 8:2 |
| rd_ptag_i | input | 23 | Translated physical tag, bits 31:9 |
| rd_hit_o | output | 1 | Read hit this cycle |
| rd_data_o | output | 32 | Read data |
| fill_alloc_i | input | 1 | Allocate a line for a new block |
| fill_idx_i | input | 6 | Set of the allocation |
| fill_tag_i | input | 23 | Tag of the allocated block |
| fill_we_i | input | 1 | Write one longword of the pending block |
| fill_lw_i | input | 1 | Longword select of the write |
| fill_data_i | input | 32 | Longword data |
| fill_par_i | input | 4 | Per-byte parity carried with the data |
| fill_err_i | input | 1 | Transfer error on this longword |
| inv_req_i | input | 1 | Invalidate request |
| inv_idx_i | input | 6 | Set of the invalidate |
| inv_tag_i | input | 23 | Tag of the invalidate |
| rfsh_row_o | output | 6 | Row to refresh |

## Verification
A wrong valid bit or tag shows at the ports in the very next lookup of that set: it appears as a hit that should have missed, or the reverse. So each fill, invalidate and replacement is followed directly by reads of both longwords of every tag involved. Bad parity state appears only on the longword that holds it, so both words are read separately. A stuck or short refresh sequence shows within 64 idle cycles as a row that is never visited or a pointer that does not move.

// File: rtl/l1c_pkg.sv
package l1c_pkg;
  localparam int LW_W  = 32;
  localparam int LW_BY = LW_W / 8;

  typedef struct packed {
    logic [LW_BY-1:0] par;
    logic [LW_W-1:0]  data;
  } lw_ent_t;

  function automatic logic [LW_BY-1:0] byte_par(logic [LW_W-1:0] d);
    logic [LW_BY-1:0] p;
    for (int k = 0; k < LW_BY; k++) p[k] = ^d[8*k +: 8];
    return p;
  endfunction
endpackage

// File: rtl/l1c_lfsr.sv
module l1c_lfsr #(
  parameter int         W    = 6,
  parameter logic [W-1:0] TAPS = 6'b110000,
  parameter bit         FULL = 1'b1   // visit the all-zero state too
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] RST_VAL = FULL ? '0 : W'(1);

  logic [W-1:0] st_q;
  logic         fb;

  always_comb begin
    fb = ^(st_q & TAPS);
    if (FULL) fb = fb ^ (st_q[W-2:0] == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= RST_VAL;
    else if (step_i) st_q <= {st_q[W-2:0], fb};
  end

  assign state_o = st_q;
endmodule

// File: rtl/l1c_way.sv
module l1c_way
  import l1c_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             rd_lw_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             rd_hit_o,
  output logic [LW_W-1:0]  rd_data_o,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  output logic             inv_hit_o,
  input  logic [IDX_W-1:0] chk_idx_i,
  output logic             chk_vld_o,
  input  logic             tag_we_i,
  input  logic [IDX_W-1:0] tag_idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             dat_we_i,
  input  logic [IDX_W-1:0] dat_idx_i,
  input  logic             dat_lw_i,
  input  lw_ent_t          dat_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_a_i,
  input  logic [IDX_W-1:0] clr_a_idx_i,
  input  logic             clr_b_i,
  input  logic [IDX_W-1:0] clr_b_idx_i
);
  logic [SETS-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  lw_ent_t          dat_q [SETS][2];
  lw_ent_t          rd_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else begin
      if (set_i)   vld_q[set_idx_i]   <= 1'b1;
      if (clr_a_i) vld_q[clr_a_idx_i] <= 1'b0;
      if (clr_b_i) vld_q[clr_b_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (tag_we_i) tag_q[tag_idx_i] <= tag_i;
    if (dat_we_i) dat_q[dat_idx_i][dat_lw_i] <= dat_i;
  end

  assign rd_ent    = dat_q[rd_idx_i][rd_lw_i];
  assign rd_hit_o  = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i)
                     && (byte_par(rd_ent.data) == rd_ent.par);
  assign rd_data_o = rd_ent.data;
  assign inv_hit_o = vld_q[inv_idx_i] && (tag_q[inv_idx_i] == inv_tag_i);
  assign chk_vld_o = vld_q[chk_idx_i];
endmodule

// File: rtl/l1c_top.sv
module l1c_top
  import l1c_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          SETS      = 64,
  parameter logic [5:0]  RFSH_TAPS = 6'b110000,
  parameter logic [7:0]  RAND_TAPS = 8'b10111000,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = 3,
  localparam int VIDX_W = IDX_W + OFF_W,
  localparam int TAG_W  = ADDR_W - VIDX_W,
  localparam int WAYS   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              icache_only_i,
  input  logic              rd_req_i,
  input  logic              rd_instr_i,
  input  logic [VIDX_W-3:0] rd_vaddr_i,
  input  logic [TAG_W-1:0]  rd_ptag_i,
  output logic              rd_hit_o,
  output logic [LW_W-1:0]   rd_data_o,
  input  logic              fill_alloc_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              fill_we_i,
  input  logic              fill_lw_i,
  input  logic [LW_W-1:0]   fill_data_i,
  input  logic [LW_BY-1:0]  fill_par_i,
  input  logic              fill_err_i,
  input  logic              inv_req_i,
  input  logic [IDX_W-1:0]  inv_idx_i,
  input  logic [TAG_W-1:0]  inv_tag_i,
  output logic [IDX_W-1:0]  rfsh_row_o
);
  logic [WAYS-1:0] way_hit, inv_hit, chk_vld;
  logic [LW_W-1:0] way_data [WAYS];
  logic [7:0]      rnd_st;
  logic            victim;

  logic             pend_q, pend_way_q, bad_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [1:0]       got_q;

  logic [1:0]       lw_mask, got_n;
  logic             wr_fire, inv_same, bad_n, validate, idle;
  logic [IDX_W-1:0] tgt_idx;

  // victim: first invalid way, else random
  assign victim = !chk_vld[0] ? 1'b0 : !chk_vld[1] ? 1'b1 : ^rnd_st;

  assign lw_mask  = fill_lw_i ? 2'b10 : 2'b01;
  assign wr_fire  = pend_q && fill_we_i && !fill_alloc_i;
  assign tgt_idx  = fill_alloc_i ? fill_idx_i : pend_idx_q;
  assign inv_same = inv_req_i && (fill_alloc_i || pend_q) && (inv_idx_i == tgt_idx);
  assign got_n    = got_q | lw_mask;
  assign bad_n    = bad_q | fill_err_i | inv_same;
  assign validate = wr_fire && (got_n == 2'b11) && !bad_n;
  assign idle     = !(rd_req_i || fill_alloc_i || fill_we_i || inv_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_way_q <= 1'b0;
      pend_idx_q <= '0;
      got_q      <= '0;
      bad_q      <= 1'b0;
    end else if (fill_alloc_i) begin
      pend_q     <= 1'b1;
      pend_way_q <= victim;
      pend_idx_q <= fill_idx_i;
      got_q      <= '0;
      bad_q      <= inv_same;
    end else if (wr_fire) begin
      got_q <= got_n;
      bad_q <= bad_n;
      if (got_n == 2'b11) pend_q <= 1'b0;
    end else if (inv_same) begin
      bad_q <= 1'b1;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    l1c_way #(.SETS(SETS), .TAG_W(TAG_W)) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_idx_i   (rd_vaddr_i[VIDX_W-3:1]),
      .rd_lw_i    (rd_vaddr_i[0]),
      .rd_tag_i   (rd_ptag_i),
      .rd_hit_o   (way_hit[w]),
      .rd_data_o  (way_data[w]),
      .inv_idx_i  (inv_idx_i),
      .inv_tag_i  (inv_tag_i),
      .inv_hit_o  (inv_hit[w]),
      .chk_idx_i  (fill_idx_i),
      .chk_vld_o  (chk_vld[w]),
      .tag_we_i   (fill_alloc_i && (victim == 1'(w))),
      .tag_idx_i  (fill_idx_i),
      .tag_i      (fill_tag_i),
      .dat_we_i   (wr_fire && (pend_way_q == 1'(w))),
      .dat_idx_i  (pend_idx_q),
      .dat_lw_i   (fill_lw_i),
      .dat_i      ({fill_par_i, fill_data_i}),
      .set_i      (validate && (pend_way_q == 1'(w))),
      .set_idx_i  (pend_idx_q),
      .clr_a_i    (fill_alloc_i && (victim == 1'(w))),
      .clr_a_idx_i(fill_idx_i),
      .clr_b_i    (inv_req_i && inv_hit[w]),
      .clr_b_idx_i(inv_idx_i)
    );
  end

  assign rd_hit_o  = rd_req_i && (!icache_only_i || rd_instr_i) && (|way_hit);
  assign rd_data_o = way_hit[1] ? way_data[1] : way_data[0];

  l1c_lfsr #(.W(8), .TAPS(RAND_TAPS), .FULL(1'b0)) u_rand (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(1'b1), .state_o(rnd_st)
  );

  l1c_lfsr #(.W(IDX_W), .TAPS(RFSH_TAPS[IDX_W-1:0]), .FULL(1'b1)) u_rfsh (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(idle), .state_o(rfsh_row_o)
  );
endmodule

// File: rtl/l1c_chk.sv
module l1c_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             icache_only_i,
  input logic             rd_req_i,
  input logic             rd_instr_i,
  input logic             rd_hit_o,
  input logic             fill_alloc_i,
  input logic             fill_we_i,
  input logic             inv_req_i,
  input logic [IDX_W-1:0] rfsh_row_o
);
  logic busy;
  assign busy = rd_req_i || fill_alloc_i || fill_we_i || inv_req_i;

  p_hit_needs_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> rd_req_i);

  p_icache_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_o && icache_only_i) |-> rd_instr_i);

  p_rfsh_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(rfsh_row_o));

  p_rfsh_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> (rfsh_row_o != $past(rfsh_row_o)));

  p_hit_known_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(rd_hit_o));
endmodule

bind l1c_top l1c_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .icache_only_i(icache_only_i),
  .rd_req_i     (rd_req_i),
  .rd_instr_i   (rd_instr_i),
  .rd_hit_o     (rd_hit_o),
  .fill_alloc_i (fill_alloc_i),
  .fill_we_i    (fill_we_i),
  .inv_req_i    (inv_req_i),
  .rfsh_row_o   (rfsh_row_o)
);

// File: tb/sim_l1c_top.sv
module sim_l1c_top;
  localparam int CLK_P = 10;
  localparam int TW    = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic icache_only = 1'b0, rd_req = 1'b0, rd_instr = 1'b0;
  logic [6:0] rd_vaddr = '0;
  logic [TW-1:0] rd_ptag = '0;
  logic rd_hit;
  logic [31:0] rd_data;
  logic fill_alloc = 1'b0, fill_we = 1'b0, fill_lw = 1'b0, fill_err = 1'b0;
  logic [5:0] fill_idx = '0;
  logic [TW-1:0] fill_tag = '0;
  logic [31:0] fill_data = '0;
  logic [3:0] fill_par = '0;
  logic inv_req = 1'b0;
  logic [5:0] inv_idx = '0;
  logic [TW-1:0] inv_tag = '0;
  logic [5:0] rfsh_row;

  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  l1c_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .icache_only_i(icache_only),
    .rd_req_i(rd_req), .rd_instr_i(rd_instr), .rd_vaddr_i(rd_vaddr),
    .rd_ptag_i(rd_ptag), .rd_hit_o(rd_hit), .rd_data_o(rd_data),
    .fill_alloc_i(fill_alloc), .fill_idx_i(fill_idx), .fill_tag_i(fill_tag),
    .fill_we_i(fill_we), .fill_lw_i(fill_lw), .fill_data_i(fill_data),
    .fill_par_i(fill_par), .fill_err_i(fill_err), .inv_req_i(inv_req),
    .inv_idx_i(inv_idx), .inv_tag_i(inv_tag), .rfsh_row_o(rfsh_row)
  );

  function automatic logic [3:0] par_of(logic [31:0] d);
    logic [3:0] p = '0;
    for (int b = 0; b < 32; b++) p[b/8] = p[b/8] ^ d[b];
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // lookup in the low phase, no edge involved
  task automatic rd(input bit instr, input logic [5:0] idx, input bit lw,
                    input logic [TW-1:0] tag, output bit hit, output logic [31:0] data);
    rd_req = 1'b1; rd_instr = instr; rd_vaddr = {idx, lw}; rd_ptag = tag;
    #1;
    hit = rd_hit; data = rd_data;
    rd_req = 1'b0;
  endtask

  task automatic rd_chk(input string req, input bit instr, input logic [5:0] idx, input bit lw,
                        input logic [TW-1:0] tag, input bit exp_hit, input logic [31:0] exp_d);
    bit h; logic [31:0] d;
    rd(instr, idx, lw, tag, h, d);
    check(h == exp_hit, req, 64'(h), 64'(exp_hit));
    if (exp_hit && h) check(d == exp_d, req, 64'(d), 64'(exp_d));
  endtask

  task automatic alloc(input logic [5:0] idx, input logic [TW-1:0] tag);
    @(negedge clk);
    fill_alloc = 1'b1; fill_idx = idx; fill_tag = tag;
    @(negedge clk);
    fill_alloc = 1'b0;
  endtask

  // caller is at a negedge; drives one longword write over the next edge
  task automatic wr_lw(input bit lw, input logic [31:0] d, input logic [3:0] flip, input bit err);
    fill_we = 1'b1; fill_lw = lw; fill_data = d; fill_par = par_of(d) ^ flip; fill_err = err;
    @(negedge clk);
    fill_we = 1'b0; fill_err = 1'b0;
  endtask

  task automatic fill(input logic [5:0] idx, input logic [TW-1:0] tag,
                      input logic [31:0] d0, input logic [31:0] d1);
    alloc(idx, tag);
    wr_lw(1'b0, d0, 4'h0, 1'b0);
    wr_lw(1'b1, d1, 4'h0, 1'b0);
  endtask

  task automatic t_reset;
    check(rfsh_row == 6'd0, "R10 reset row", 64'(rfsh_row), 64'd0);
    rd_chk("R2 cold miss", 1'b0, 6'd0, 1'b0, '0, 1'b0, '0);
    rd_chk("R2 cold miss", 1'b1, 6'd17, 1'b1, 23'h1, 1'b0, '0);
  endtask

  task automatic t_basic;
    alloc(6'd3, 23'h12345);
    wr_lw(1'b1, 32'hB1B1_0003, 4'h0, 1'b0);   // second word first
    rd_chk("R3 miss mid fill", 1'b0, 6'd3, 1'b1, 23'h12345, 1'b0, '0);
    wr_lw(1'b0, 32'hA0A0_0003, 4'h0, 1'b0);
    rd_chk("R3 hit lw0", 1'b0, 6'd3, 1'b0, 23'h12345, 1'b1, 32'hA0A0_0003);
    rd_chk("R1 hit lw1", 1'b0, 6'd3, 1'b1, 23'h12345, 1'b1, 32'hB1B1_0003);
    rd_chk("R1 tag mismatch", 1'b0, 6'd3, 1'b0, 23'h12344, 1'b0, '0);
    rd_chk("R1 other set", 1'b0, 6'd4, 1'b0, 23'h12345, 1'b0, '0);
    rd_req = 1'b0; rd_vaddr = {6'd3, 1'b0}; rd_ptag = 23'h12345; #1;
    check(rd_hit == 1'b0, "R11 no req no hit", 64'(rd_hit), 64'd0);
  endtask

  task automatic t_err;
    alloc(6'd8, 23'h00888);
    wr_lw(1'b0, 32'h1111_2222, 4'h0, 1'b1);
    wr_lw(1'b1, 32'h3333_4444, 4'h0, 1'b0);
    rd_chk("R4 err lw0", 1'b0, 6'd8, 1'b0, 23'h00888, 1'b0, '0);
    rd_chk("R4 err lw1", 1'b0, 6'd8, 1'b1, 23'h00888, 1'b0, '0);
  endtask

  task automatic t_victim;
    for (int s = 0; s < 4; s++) begin
      bit ha, hb; logic [31:0] d;
      logic [5:0] ix = 6'(20 + s);
      fill(ix, 23'h0A000 + 23'(s), 32'hAAAA_0000 + s, 32'hAAAA_1000 + s);
      fill(ix, 23'h0B000 + 23'(s), 32'hBBBB_0000 + s, 32'hBBBB_1000 + s);
      rd_chk("R5 first way kept", 1'b0, ix, 1'b0, 23'h0A000 + 23'(s), 1'b1, 32'hAAAA_0000 + s);
      rd_chk("R5 second way used", 1'b0, ix, 1'b1, 23'h0B000 + 23'(s), 1'b1, 32'hBBBB_1000 + s);
      repeat (s) @(negedge clk);
      fill(ix, 23'h0C000 + 23'(s), 32'hCCCC_0000 + s, 32'hCCCC_1000 + s);
      rd_chk("R5 new line hits", 1'b0, ix, 1'b0, 23'h0C000 + 23'(s), 1'b1, 32'hCCCC_0000 + s);
      rd(1'b0, ix, 1'b0, 23'h0A000 + 23'(s), ha, d);
      rd(1'b0, ix, 1'b0, 23'h0B000 + 23'(s), hb, d);
      check((32'(ha) + 32'(hb)) == 1, "R5 one displaced", 64'(32'(ha) + 32'(hb)), 64'd1);
    end
  endtask

  task automatic t_parity;
    alloc(6'd40, 23'h04040);
    wr_lw(1'b0, 32'h5A5A_1234, 4'h0, 1'b0);
    wr_lw(1'b1, 32'h0F0F_8001, 4'h4, 1'b0);   // byte 2 parity wrong
    rd_chk("R6 bad byte miss", 1'b0, 6'd40, 1'b1, 23'h04040, 1'b0, '0);
    rd_chk("R6 good lw hit", 1'b0, 6'd40, 1'b0, 23'h04040, 1'b1, 32'h5A5A_1234);
  endtask

  task automatic t_imode;
    @(negedge clk); icache_only = 1'b1;
    rd_chk("R7 data bypass", 1'b0, 6'd3, 1'b0, 23'h12345, 1'b0, '0);
    rd_chk("R7 instr hit", 1'b1, 6'd3, 1'b1, 23'h12345, 1'b1, 32'hB1B1_0003);
    @(negedge clk); icache_only = 1'b0;
    rd_chk("R7 data hit again", 1'b0, 6'd3, 1'b0, 23'h12345, 1'b1, 32'hA0A0_0003);
  endtask

  task automatic t_inv;
    fill(6'd50, 23'h05001, 32'h5001_0000, 32'h5001_0001);
    fill(6'd50, 23'h05002, 32'h5002_0000, 32'h5002_0001);
    inv_req = 1'b1; inv_idx = 6'd50; inv_tag = 23'h05777;
    @(negedge clk); inv_req = 1'b0;
    rd_chk("R8 no match kept", 1'b0, 6'd50, 1'b0, 23'h05001, 1'b1, 32'h5001_0000);
    inv_req = 1'b1; inv_tag = 23'h05001;
    @(negedge clk); inv_req = 1'b0;
    rd_chk("R8 matched gone", 1'b0, 6'd50, 1'b1, 23'h05001, 1'b0, '0);
    rd_chk("R8 other way kept", 1'b0, 6'd50, 1'b1, 23'h05002, 1'b1, 32'h5002_0001);
  endtask

  task automatic t_inv_fill;
    alloc(6'd60, 23'h06060);
    wr_lw(1'b0, 32'h6060_0000, 4'h0, 1'b0);
    inv_req = 1'b1; inv_idx = 6'd60; inv_tag = 23'h06060;
    wr_lw(1'b1, 32'h6060_0001, 4'h0, 1'b0);
    inv_req = 1'b0;
    rd_chk("R9 same set abort", 1'b0, 6'd60, 1'b0, 23'h06060, 1'b0, '0);
    alloc(6'd61, 23'h06161);
    wr_lw(1'b0, 32'h6161_0000, 4'h0, 1'b0);
    inv_req = 1'b1; inv_idx = 6'd62; inv_tag = 23'h06161;
    wr_lw(1'b1, 32'h6161_0001, 4'h0, 1'b0);
    inv_req = 1'b0;
    rd_chk("R9 other set kept", 1'b0, 6'd61, 1'b1, 23'h06161, 1'b1, 32'h6161_0001);
  endtask

  task automatic t_rfsh;
    logic [63:0] seen = '0;
    logic [5:0] r0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      seen[rfsh_row] = 1'b1;
      @(negedge clk);
    end
    check(seen == '1, "R10 all rows", seen, '1);
    r0 = rfsh_row;
    inv_req = 1'b1; inv_idx = 6'd1; inv_tag = 23'h7FFFF;
    repeat (3) @(negedge clk);
    inv_req = 1'b0;
    check(rfsh_row == r0, "R10 hold busy", 64'(rfsh_row), 64'(r0));
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_basic();
    t_err();
    t_victim();
    t_parity();
    t_imode();
    t_inv();
    t_inv_fill();
    t_rfsh();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule